// File: doc/BRIEF.md
# Adapter Control and Window Mapper

This block is the host-side control logic of a network adapter's gate array. The host reaches it with single-cycle byte reads and writes. Sixteen registers sit at offset 0x400 from the I/O base, and a 16-byte window sits at offset 0x000. A control register decides what the window shows: the network controller's registers, the lower half of the station-address PROM, or the upper half. Window reads and writes go to the selected target. Writes to a PROM half are dropped.

The control register also carries a software reset bit. While that bit is set, every other gate-array register is held at its reset value. The write that releases the bit leaves the control register at a fixed value: upper PROM half mapped and transceiver select set. The block also reports a status byte, made of a fixed gate-array revision and five live DMA and FIFO flags. It presents the shared-memory base strap as a one-hot configuration byte. The PROM and the network controller are outside the block, behind simple read and write ports.

Host read data is registered. It appears one cycle after the read strobe and is zero in every other cycle. The host port has no back-pressure: every strobe completes in one cycle.

Top module: `adapter_gate_array`

## Requirements
- R1: After reset the control register reads 0x0A and `window_sel` is 2, so the upper PROM half (PROM bytes 16–31) is mapped.
- R2: A write to offset 0x406 with bit 0 clear, while the reset bit is clear, stores the written byte, and a read of 0x406 returns it.
- R3: A write to 0x406 with bit 0 set makes the control register read 0x0B. The next write to 0x406 with bit 0 clear makes it read 0x0A, whatever the other written bits are.
- R4: While control bit 0 is set, the general gate-array registers read 0, and writes to them have no effect.
- R5: `window_sel` encodes control bits 3:2 as follows. 00 gives 0, the controller. Bit 2 set gives 1, PROM bytes 0–15. Only bit 3 set gives 2, PROM bytes 16–31. Both set gives 1. Reads of window offsets 0x00–0x0F return the selected target's byte at that offset, and for PROM the PROM address is {high-half, offset}.
- R6: A window write reaches the controller (`nic_wr` with address and data) only when `window_sel` is 0. Writes while a PROM half is mapped change nothing.
- R7: `host_rdata` holds the value addressed by a read in the cycle after `host_rd`, and 0 in every cycle that does not follow a read. `nic_rd` pulses only for window reads with the controller mapped.
- R8: Offset 0x404 reads {`mem_base_code`, 4'b0}, where bits 4..7 stand for bases 0xC8000, 0xCC000, 0xD8000 and 0xDC000. The register ignores writes.
- R9: Offset 0x407 reads {port_ready, fifo_unf, fifo_ovf, dma_tc, dma_busy, REV[2:0]}. The register ignores writes.
- R10: Gate-array offsets other than 0x404, 0x406 and 0x407 are byte registers that read back what was last written to them. They reset to 0.
- R11: `xcvr_bnc` follows control bit 1 (1 = BNC, 0 = AUI).
- R12: Addresses outside the window and the gate-array block read 0. Writes to them change no register and are not forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_addr | input | ADDR_W | Host byte address relative to the I/O base |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered host read data |
| prom_addr | output | 5 | Station-address PROM byte address |
| prom_data | input | 8 | PROM byte at prom_addr |
| nic_addr | output | 4 | Controller register offset |
| nic_wr | output | 1 | Controller write strobe |
| nic_rd | output | 1 | Controller read strobe |
| nic_wdata | output | 8 | Controller write data |
| nic_rdata | input | 8 | Controller register byte at nic_addr |
| mem_base_code | input | 4 | One-hot shared-memory base strap |
| dma_busy | input | 1 | DMA in progress |
| dma_tc | input | 1 | DMA terminal count reached |
| fifo_ovf | input | 1 | Data FIFO overflow |
| fifo_unf | input | 1 | Data FIFO underflow |
| port_ready | input | 1 | Data port ready |
| xcvr_bnc | output | 1 | Transceiver select |
| window_sel | output | 2 | Current window target |

## Verification
All four values of control bits 3:2 are applied, and all sixteen window offsets are read under each. A PROM model whose bytes differ by offset and half tells the two halves apart, and tells each half from the controller. The `nic_rd` pulse count separates controller reads from PROM reads. All 32 status-flag combinations and all 16 strap codes are swept, which tells bit positions apart. The reset bit is set, then released with data that carries other bits, to show that the release value is fixed.

// File: rtl/ga_pkg.sv
package ga_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned WIN_BYTES = 16;
  localparam int unsigned OFS_W = $clog2(WIN_BYTES);

  localparam logic [OFS_W-1:0] OFS_MEMCFG = 4'h4;
  localparam logic [OFS_W-1:0] OFS_CTRL   = 4'h6;
  localparam logic [OFS_W-1:0] OFS_STATUS = 4'h7;

  localparam logic [DATA_W-1:0] CTRL_RELEASE = 8'h0A;
  localparam int unsigned CB_RESET = 0;
  localparam int unsigned CB_XCVR  = 1;
  localparam int unsigned CB_MAPLO = 2;
  localparam int unsigned CB_MAPHI = 3;

  typedef enum logic [1:0] {
    WIN_NIC     = 2'd0,
    WIN_PROM_LO = 2'd1,
    WIN_PROM_HI = 2'd2
  } win_e;
endpackage

// File: rtl/ga_ctrl_reg.sv
module ga_ctrl_reg
  import ga_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctrl_q,
  output logic              hold
);
  localparam logic [DATA_W-1:0] CTRL_HELD = CTRL_RELEASE | (DATA_W'(1) << CB_RESET);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RELEASE;
    end else if (wr_en) begin
      if (wdata[CB_RESET])       ctrl_q <= CTRL_HELD;
      else if (ctrl_q[CB_RESET]) ctrl_q <= CTRL_RELEASE;
      else                       ctrl_q <= wdata;
    end
  end

  assign hold = ctrl_q[CB_RESET];

  assert_rst_enter_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wdata[CB_RESET]) |=> (ctrl_q == 8'h0B));
  assert_rst_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wdata[CB_RESET] && hold) |=> (ctrl_q == 8'h0A));
  assert_ctrl_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ctrl_q));
endmodule

// File: rtl/ga_scratch.sv
module ga_scratch
  import ga_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic              wr_en,
  input  logic [OFS_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [OFS_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] regs [WIN_BYTES];

  for (genvar g = 0; g < WIN_BYTES; g++) begin : g_reg
    localparam bit STORED = (g != int'(OFS_MEMCFG)) && (g != int'(OFS_CTRL)) &&
                            (g != int'(OFS_STATUS));
    if (STORED) begin : g_store
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                regs[g] <= '0;
        else if (hold)                             regs[g] <= '0;
        else if (wr_en && wr_idx == OFS_W'(g))     regs[g] <= wdata;
      end
      assert_held_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (regs[g] == '0));
    end else begin : g_none
      assign regs[g] = '0;
    end
  end

  assign rd_data = regs[rd_idx];
endmodule

// File: rtl/ga_window.sv
module ga_window
  import ga_pkg::*;
(
  input  logic              map_lo,
  input  logic              map_hi,
  input  logic              hit,
  input  logic              wr,
  input  logic              rd,
  input  logic [OFS_W-1:0]  ofs,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] prom_data,
  input  logic [DATA_W-1:0] nic_rdata,
  output win_e              sel,
  output logic [OFS_W:0]    prom_addr,
  output logic [OFS_W-1:0]  nic_addr,
  output logic              nic_wr,
  output logic              nic_rd,
  output logic [DATA_W-1:0] nic_wdata,
  output logic [DATA_W-1:0] rdata
);
  always_comb begin
    if (map_lo)      sel = WIN_PROM_LO;
    else if (map_hi) sel = WIN_PROM_HI;
    else             sel = WIN_NIC;
  end

  assign prom_addr = {sel == WIN_PROM_HI, ofs};
  assign nic_addr  = ofs;
  assign nic_wdata = wdata;
  assign nic_wr    = hit && wr && (sel == WIN_NIC);
  assign nic_rd    = hit && rd && (sel == WIN_NIC);
  assign rdata     = (sel == WIN_NIC) ? nic_rdata : prom_data;
endmodule

// File: rtl/adapter_gate_array.sv
module adapter_gate_array
  import ga_pkg::*;
#(
  parameter int unsigned ADDR_W  = 11,
  parameter logic [ADDR_W-1:0] GA_BASE = 11'h400,
  parameter logic [2:0]  REV     = 3'b010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  output logic [4:0]        prom_addr,
  input  logic [7:0]        prom_data,
  output logic [3:0]        nic_addr,
  output logic              nic_wr,
  output logic              nic_rd,
  output logic [7:0]        nic_wdata,
  input  logic [7:0]        nic_rdata,
  input  logic [3:0]        mem_base_code,
  input  logic              dma_busy,
  input  logic              dma_tc,
  input  logic              fifo_ovf,
  input  logic              fifo_unf,
  input  logic              port_ready,
  output logic              xcvr_bnc,
  output logic [1:0]        window_sel
);
  localparam int unsigned PAGE_W = ADDR_W - OFS_W;
  localparam logic [PAGE_W-1:0] GA_PAGE = GA_BASE[ADDR_W-1:OFS_W];

  logic [OFS_W-1:0]  ofs;
  logic              win_hit, ga_hit;
  logic [DATA_W-1:0] ctrl_q, scr_rdata, win_rdata, ga_rdata, rd_next;
  logic              hold;
  win_e              sel;

  assign ofs     = host_addr[OFS_W-1:0];
  assign win_hit = host_addr[ADDR_W-1:OFS_W] == '0;
  assign ga_hit  = host_addr[ADDR_W-1:OFS_W] == GA_PAGE;

  ga_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .wr_en(host_wr && ga_hit && ofs == OFS_CTRL),
    .wdata(host_wdata), .ctrl_q(ctrl_q), .hold(hold)
  );

  ga_scratch u_scratch (
    .clk(clk), .rst_n(rst_n), .hold(hold),
    .wr_en(host_wr && ga_hit), .wr_idx(ofs), .wdata(host_wdata),
    .rd_idx(ofs), .rd_data(scr_rdata)
  );

  ga_window u_window (
    .map_lo(ctrl_q[CB_MAPLO]), .map_hi(ctrl_q[CB_MAPHI]),
    .hit(win_hit), .wr(host_wr), .rd(host_rd), .ofs(ofs),
    .wdata(host_wdata), .prom_data(prom_data), .nic_rdata(nic_rdata),
    .sel(sel), .prom_addr(prom_addr), .nic_addr(nic_addr),
    .nic_wr(nic_wr), .nic_rd(nic_rd), .nic_wdata(nic_wdata),
    .rdata(win_rdata)
  );

  always_comb begin
    unique case (ofs)
      OFS_MEMCFG: ga_rdata = {mem_base_code, 4'b0000};
      OFS_CTRL:   ga_rdata = ctrl_q;
      OFS_STATUS: ga_rdata = {port_ready, fifo_unf, fifo_ovf, dma_tc, dma_busy, REV};
      default:    ga_rdata = scr_rdata;
    endcase
    if (win_hit)     rd_next = win_rdata;
    else if (ga_hit) rd_next = ga_rdata;
    else             rd_next = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       host_rdata <= '0;
    else if (host_rd) host_rdata <= rd_next;
    else              host_rdata <= '0;
  end

  assign xcvr_bnc   = ctrl_q[CB_XCVR];
  assign window_sel = sel;

  assert_idle_rdata_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rd |=> (host_rdata == 8'h00));
  assert_nic_wr_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    nic_wr |-> (host_wr && ctrl_q[3:2] == 2'b00 && host_addr[ADDR_W-1:OFS_W] == '0));
  assert_memcfg_low_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && ga_hit && ofs == OFS_MEMCFG) |=> (host_rdata[3:0] == 4'h0));
  assert_status_rev_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && ga_hit && ofs == OFS_STATUS) |=> (host_rdata[2:0] == REV));
  assert_unmapped_silent_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_hit) |-> (!nic_wr && !nic_rd));
endmodule

// File: tb/adapter_gate_array_tb_top.sv
module adapter_gate_array_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [10:0] host_addr = '0;
  logic host_wr = 0, host_rd = 0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic [4:0] prom_addr;
  logic [7:0] prom_data;
  logic [3:0] nic_addr;
  logic nic_wr, nic_rd;
  logic [7:0] nic_wdata, nic_rdata;
  logic [3:0] mem_base_code = 4'b0001;
  logic dma_busy = 0, dma_tc = 0, fifo_ovf = 0, fifo_unf = 0, port_ready = 0;
  logic xcvr_bnc;
  logic [1:0] window_sel;

  int checks = 0, failures = 0, nic_rd_count = 0;
  logic [7:0] nic_mem [16];
  logic [7:0] v;

  always #10 clk = ~clk;

  adapter_gate_array dut_i (.*);

  function automatic logic [7:0] prom_val(input logic [4:0] a);
    return 8'(a * 13 + 5);
  endfunction

  assign prom_data = prom_val(prom_addr);
  assign nic_rdata = nic_mem[nic_addr];

  always @(posedge clk) begin
    if (nic_wr) nic_mem[nic_addr] <= nic_wdata;
    if (nic_rd) nic_rd_count <= nic_rd_count + 1;
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [10:0] a, input logic [7:0] d);
    @(negedge clk); host_addr = a; host_wdata = d; host_wr = 1;
    @(negedge clk); host_wr = 0;
  endtask

  task automatic rd(input logic [10:0] a, output logic [7:0] d);
    @(negedge clk); host_addr = a; host_rd = 1;
    @(negedge clk); host_rd = 0; d = host_rdata;
  endtask

  initial begin
    #4_000_000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int base;
    logic [7:0] e;
    for (int i = 0; i < 16; i++) nic_mem[i] = 8'h80 + 8'(i);
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 / R11 reset state
    rd(11'h406, v); check("R1 ctrl", v, 8'h0A);
    check("R1 window_sel", {6'b0, window_sel}, 8'd2);
    check("R11 xcvr", {7'b0, xcvr_bnc}, 8'd1);
    // R7 idle cycle after read reads zero
    @(negedge clk); check("R7 idle rdata", host_rdata, 8'h00);
    // R5 window sweep, R7 nic_rd counting
    for (int m = 0; m < 4; m++) begin
      wr(11'h406, 8'(m << 2));
      e = (m == 0) ? 8'd0 : (m == 2) ? 8'd2 : 8'd1;
      check("R5 window_sel", {6'b0, window_sel}, e);
      base = nic_rd_count;
      for (int o = 0; o < 16; o++) begin
        rd(11'(o), v);
        if (m == 0) e = nic_mem[o];
        else if (m == 2) e = prom_val(5'(16 + o));
        else e = prom_val(5'(o));
        check("R5 window data", v, e);
      end
      check("R7 nic_rd count", 8'(nic_rd_count - base), (m == 0) ? 8'd16 : 8'd0);
    end
    // R6 window writes
    wr(11'h406, 8'h00); wr(11'h003, 8'h5A);
    check("R6 nic write", nic_mem[3], 8'h5A);
    wr(11'h406, 8'h04); wr(11'h005, 8'hA5);
    check("R6 prom lo write dropped", nic_mem[5], 8'h85);
    wr(11'h406, 8'h08); wr(11'h006, 8'hA6);
    check("R6 prom hi write dropped", nic_mem[6], 8'h86);
    // R2 / R11 control writes
    wr(11'h406, 8'hF2); rd(11'h406, v); check("R2 ctrl F2", v, 8'hF2);
    check("R11 xcvr set", {7'b0, xcvr_bnc}, 8'd1);
    wr(11'h406, 8'h30); rd(11'h406, v); check("R2 ctrl 30", v, 8'h30);
    check("R11 xcvr clear", {7'b0, xcvr_bnc}, 8'd0);
    // R10 scratch sweep
    for (int o = 0; o < 16; o++)
      if (o != 4 && o != 6 && o != 7) wr(11'h400 + 11'(o), 8'(o * 17 + 1));
    for (int o = 0; o < 16; o++)
      if (o != 4 && o != 6 && o != 7) begin
        rd(11'h400 + 11'(o), v); check("R10 scratch", v, 8'(o * 17 + 1));
      end
    // R8 config sweep, writes ignored
    wr(11'h404, 8'hFF);
    for (int c = 0; c < 16; c++) begin
      mem_base_code = 4'(c);
      rd(11'h404, v); check("R8 memcfg", v, 8'(c << 4));
    end
    // R9 status sweep
    wr(11'h407, 8'hFF);
    for (int s = 0; s < 32; s++) begin
      {port_ready, fifo_unf, fifo_ovf, dma_tc, dma_busy} = 5'(s);
      rd(11'h407, v); check("R9 status", v, 8'((s << 3) | 2));
    end
    // R3 / R4 software reset
    wr(11'h406, 8'h01); rd(11'h406, v); check("R3 held ctrl", v, 8'h0B);
    rd(11'h401, v); check("R4 scratch cleared", v, 8'h00);
    wr(11'h402, 8'h77); rd(11'h402, v); check("R4 write ignored", v, 8'h00);
    wr(11'h406, 8'hF4); rd(11'h406, v); check("R3 release", v, 8'h0A);
    check("R3 window after release", {6'b0, window_sel}, 8'd2);
    rd(11'h402, v); check("R4 still clear", v, 8'h00);
    // R12 unmapped
    wr(11'h406, 8'h00);
    wr(11'h200, 8'h11); wr(11'h013, 8'h22);
    rd(11'h200, v); check("R12 unmapped read", v, 8'h00);
    rd(11'h406, v); check("R12 ctrl unchanged", v, 8'h00);
    check("R12 nic unchanged", nic_mem[3], 8'h5A);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule